// File: doc/BRIEF.md
# Video Raster Format Detector

This block watches a 10-bit parallel digital video stream and works out which of fourteen standard- and high-definition rasters it carries. An upstream decoder flags each end-of-active-video timing word with a strobe. The block checks that the flagged word is a well-formed timing word and takes the field and vertical-blanking bits from it. From the accepted timing words it measures the words per line, the lines per frame, the number of active lines and whether the frame is interlaced.

At every frame boundary the measurements are matched against a fixed map of raster codes. A code is published, with a valid flag, only after two frames in a row give the same answer. Downstream logic that numbers lines or inserts ancillary data can then trust a stable format. Two shift parameters let the nominal line length and line counts be scaled down together, so a reduced raster can stand in for the full one.

Top module: `fmt_raster_detect`

## Requirements
- R1: While reset is high, and on the cycle after it falls, fmt_code is 00000 and fmt_valid, is_hd and is_pal are 0.
- R2: A strobed word is an accepted timing word when bit 9 = 1, bit 6 = 1, bit 8 = F, bit 7 = V, bit 5 = ~V, bit 4 = ~F, bit 3 = F^V, bit 2 = ~(F^V) and bits 1:0 = 00. Words per line are counted from one accepted timing word to the next. A frame starts at an accepted word with V = 1 and F = 0 when the previous accepted word had V = 0.
- R3: Lines per frame is the number of accepted timing words in the frame. Active lines are those words with V = 0. The frame is interlaced if any of its words has F = 1. Measured line lengths are compared with the nominal value shifted right by LEN_SHIFT, and line and active counts with the nominal value shifted right by LINE_SHIFT.
- R4: Standard definition, any scan: 1716 / 2288 / 3432 words over 525 lines give 00011 / 00010 / 00001. 1728 / 2304 / 3456 words over 625 lines give 01011 / 01010 / 01001.
- R5: 2200 words over 1125 lines give 10011 if progressive. If interlaced, they give 10001 with 1035 active lines and 10010 with 1080 active lines.
- R6: 2640 words over 1125 lines give 11010 progressive and 11001 interlaced. 2376 over 1250 interlaced gives 11100. 2750 over 1125 progressive gives 11101. 1650 over 750 progressive gives 10100. These lengths with the other scan type match nothing.
- R7: Results change only two clock edges after the timing word that starts a frame. fmt_valid rises only when two consecutive frames classify to the same nonzero code. While fmt_valid is 0, fmt_code is 00000.
- R8: A frame that matches no entry, or whose lines are not all the same length, clears fmt_valid and fmt_code at its boundary. So does a frame whose code differs from the previous frame.
- R9: A strobed word that is not well formed (per R2) is ignored. It neither ends a line nor starts a frame.
- R10: is_hd equals fmt_code bit 4 (high definition) and is_pal equals fmt_code bit 3 (625/50 family).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock, one video word per cycle |
| rst | input | 1 | Synchronous active-high reset |
| vid_word | input | 10 | Parallel video word |
| eav_stb | input | 1 | Marks vid_word as an end-of-active-video timing word |
| fmt_code | output | 5 | Detected raster code, 00000 when not locked |
| fmt_valid | output | 1 | Format locked |
| is_hd | output | 1 | Locked raster is high definition |
| is_pal | output | 1 | Locked raster is of the 625/50 family |

## Verification
Every internal fault in this block surfaces at one port: the lock flag and code sampled just after a frame boundary. A miscounted line, active or word counter turns a known raster into a no-match, so the valid flag drops at the next boundary and stays low within two frames. A stale match history instead asserts the flag one frame early, or holds an old code across a format change. That shows at the boundary that follows the change. An accepted malformed timing word splits a frame in two, so lock is lost within one frame.

// File: rtl/fmt_pkg.sv
`timescale 1ns/1ps
package fmt_pkg;

    localparam int NUM_FMT    = 14;
    localparam int NOM_LEN_W  = 12;
    localparam int NOM_LINE_W = 11;
    localparam int CODE_W     = 5;

    typedef enum logic [1:0] {
        SCAN_ANY  = 2'd0,
        SCAN_INTL = 2'd1,
        SCAN_PROG = 2'd2
    } scan_e;

    // One raster entry; active == 0 means the active count is not checked
    typedef struct packed {
        logic [CODE_W-1:0]     code;
        logic [NOM_LEN_W-1:0]  words;
        logic [NOM_LINE_W-1:0] lines;
        logic [NOM_LINE_W-1:0] active;
        scan_e                 scan;
    } fmt_ent_t;

    // Accepted timing-word event
    typedef struct packed {
        logic acc;
        logic f;
        logic v;
    } trs_evt_t;

    function automatic fmt_ent_t mk_ent(logic [CODE_W-1:0] c, int w, int l, int a, scan_e s);
        fmt_ent_t e;
        e.code   = c;
        e.words  = NOM_LEN_W'(w);
        e.lines  = NOM_LINE_W'(l);
        e.active = NOM_LINE_W'(a);
        e.scan   = s;
        return e;
    endfunction

    function automatic fmt_ent_t fmt_entry(int idx);
        case (idx)
            0:  return mk_ent(5'b00011, 1716,  525,    0, SCAN_ANY);
            1:  return mk_ent(5'b01011, 1728,  625,    0, SCAN_ANY);
            2:  return mk_ent(5'b00010, 2288,  525,    0, SCAN_ANY);
            3:  return mk_ent(5'b01010, 2304,  625,    0, SCAN_ANY);
            4:  return mk_ent(5'b00001, 3432,  525,    0, SCAN_ANY);
            5:  return mk_ent(5'b01001, 3456,  625,    0, SCAN_ANY);
            6:  return mk_ent(5'b10011, 2200, 1125,    0, SCAN_PROG);
            7:  return mk_ent(5'b10001, 2200, 1125, 1035, SCAN_INTL);
            8:  return mk_ent(5'b10010, 2200, 1125, 1080, SCAN_INTL);
            9:  return mk_ent(5'b11010, 2640, 1125,    0, SCAN_PROG);
            10: return mk_ent(5'b11001, 2640, 1125,    0, SCAN_INTL);
            11: return mk_ent(5'b11100, 2376, 1250,    0, SCAN_INTL);
            12: return mk_ent(5'b11101, 2750, 1125,    0, SCAN_PROG);
            13: return mk_ent(5'b10100, 1650,  750,    0, SCAN_PROG);
            default: return mk_ent(5'b00000, 0, 0, 0, SCAN_ANY);
        endcase
    endfunction

    function automatic logic fmt_code_legal(logic [CODE_W-1:0] c);
        logic ok;
        ok = 1'b0;
        for (int i = 0; i < NUM_FMT; i++) begin
            if (fmt_entry(i).code == c) ok = 1'b1;
        end
        return ok;
    endfunction

    // Well-formed XYZ timing word with H = 1 and correct protection bits
    function automatic logic fmt_xyz_ok(logic [9:0] w);
        return w[9] && w[6]
            && (w[5] == ~w[7])
            && (w[4] == ~w[8])
            && (w[3] == (w[8] ^ w[7]))
            && (w[2] == ~(w[8] ^ w[7]))
            && (w[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/fmt_trs_meter.sv
`timescale 1ns/1ps
module fmt_trs_meter
    import fmt_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [9:0]       vid_word,
    input  logic             eav_stb,
    output trs_evt_t         evt,
    output logic [LEN_W-1:0] line_len
);

    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic [LEN_W-1:0] word_cnt;

    assign evt.acc  = eav_stb && fmt_xyz_ok(vid_word);
    assign evt.f    = vid_word[8];
    assign evt.v    = vid_word[7];
    assign line_len = word_cnt;

    // Counts words since the last accepted timing word, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            word_cnt <= '0;
        end else if (evt.acc) begin
            word_cnt <= LEN_W'(1);
        end else if (word_cnt != LEN_MAX) begin
            word_cnt <= word_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fmt_frame_meter.sv
`timescale 1ns/1ps
module fmt_frame_meter
    import fmt_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  trs_evt_t          evt,
    input  logic [LEN_W-1:0]  line_len,
    output logic              meas_vld,
    output logic [LEN_W-1:0]  meas_len,
    output logic [LINE_W-1:0] meas_lines,
    output logic [LINE_W-1:0] meas_active,
    output logic              meas_il,
    output logic              meas_bad
);

    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic              prev_v;
    logic              synced;
    logic              len_armed;
    logic              len_bad;
    logic              il_seen;
    logic [LEN_W-1:0]  ref_len;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] act_cnt;
    logic              frame_edge;

    assign frame_edge = evt.acc && evt.v && !prev_v && !evt.f;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_v      <= 1'b0;
            synced      <= 1'b0;
            len_armed   <= 1'b0;
            len_bad     <= 1'b0;
            il_seen     <= 1'b0;
            ref_len     <= '0;
            line_cnt    <= '0;
            act_cnt     <= '0;
            meas_vld    <= 1'b0;
            meas_len    <= '0;
            meas_lines  <= '0;
            meas_active <= '0;
            meas_il     <= 1'b0;
            meas_bad    <= 1'b0;
        end else begin
            meas_vld <= 1'b0;
            if (evt.acc) begin
                prev_v <= evt.v;
                if (frame_edge) begin
                    if (synced) begin
                        meas_vld    <= 1'b1;
                        meas_len    <= ref_len;
                        meas_lines  <= line_cnt;
                        meas_active <= act_cnt;
                        meas_il     <= il_seen;
                        meas_bad    <= len_bad || !len_armed || (line_len != ref_len);
                    end
                    synced    <= 1'b1;
                    line_cnt  <= LINE_W'(1);
                    act_cnt   <= '0;
                    il_seen   <= 1'b0;
                    len_armed <= 1'b0;
                    len_bad   <= 1'b0;
                end else begin
                    if (line_cnt != LINE_MAX) line_cnt <= line_cnt + 1'b1;
                    if (!evt.v && act_cnt != LINE_MAX) act_cnt <= act_cnt + 1'b1;
                    if (evt.f) il_seen <= 1'b1;
                    if (!len_armed) begin
                        ref_len   <= line_len;
                        len_armed <= 1'b1;
                    end else if (line_len != ref_len) begin
                        len_bad <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fmt_classify.sv
`timescale 1ns/1ps
module fmt_classify
    import fmt_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int LINE_W     = 11,
    parameter int LEN_SHIFT  = 0,
    parameter int LINE_SHIFT = 0
) (
    input  logic [LEN_W-1:0]  meas_len,
    input  logic [LINE_W-1:0] meas_lines,
    input  logic [LINE_W-1:0] meas_active,
    input  logic              meas_il,
    input  logic              meas_bad,
    output logic [CODE_W-1:0] cand
);

    logic [NUM_FMT-1:0]  hit;
    logic [CODE_W-1:0]   code_tab [NUM_FMT];

    for (genvar i = 0; i < NUM_FMT; i++) begin : g_ent
        localparam fmt_ent_t          ENT      = fmt_entry(i);
        localparam logic [LEN_W-1:0]  EXP_LEN  = LEN_W'(ENT.words >> LEN_SHIFT);
        localparam logic [LINE_W-1:0] EXP_LINE = LINE_W'(ENT.lines >> LINE_SHIFT);
        localparam logic [LINE_W-1:0] EXP_ACT  = LINE_W'(ENT.active >> LINE_SHIFT);
        localparam logic              ACT_ANY  = (ENT.active == '0);

        logic scan_ok;
        logic act_ok;

        always_comb begin
            case (ENT.scan)
                SCAN_INTL: scan_ok = meas_il;
                SCAN_PROG: scan_ok = !meas_il;
                default:   scan_ok = 1'b1;
            endcase
        end

        assign act_ok      = ACT_ANY || (meas_active == EXP_ACT);
        assign hit[i]      = !meas_bad && (meas_len == EXP_LEN)
                             && (meas_lines == EXP_LINE) && scan_ok && act_ok;
        assign code_tab[i] = ENT.code;
    end

    // Entries are mutually exclusive, so an OR of the hit codes suffices
    always_comb begin
        cand = '0;
        for (int i = 0; i < NUM_FMT; i++) begin
            if (hit[i]) cand = cand | code_tab[i];
        end
    end

endmodule

// File: rtl/fmt_lock.sv
`timescale 1ns/1ps
module fmt_lock
    import fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              meas_vld,
    input  logic [CODE_W-1:0] cand,
    output logic [CODE_W-1:0] code_q,
    output logic              valid_q
);

    logic [CODE_W-1:0] last_cand;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_cand <= '0;
            code_q    <= '0;
            valid_q   <= 1'b0;
        end else if (meas_vld) begin
            if (cand == '0) begin
                last_cand <= '0;
                code_q    <= '0;
                valid_q   <= 1'b0;
            end else if (cand == last_cand) begin
                code_q    <= cand;
                valid_q   <= 1'b1;
            end else begin
                last_cand <= cand;
                code_q    <= '0;
                valid_q   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fmt_raster_detect.sv
`timescale 1ns/1ps
module fmt_raster_detect
    import fmt_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int LINE_W     = 11,
    parameter int LEN_SHIFT  = 0,
    parameter int LINE_SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [9:0] vid_word,
    input  logic       eav_stb,
    output logic [4:0] fmt_code,
    output logic       fmt_valid,
    output logic       is_hd,
    output logic       is_pal
);

    trs_evt_t          evt;
    logic [LEN_W-1:0]  line_len;
    logic              meas_vld;
    logic [LEN_W-1:0]  meas_len;
    logic [LINE_W-1:0] meas_lines;
    logic [LINE_W-1:0] meas_active;
    logic              meas_il;
    logic              meas_bad;
    logic [CODE_W-1:0] cand;
    logic [CODE_W-1:0] code_q;
    logic              valid_q;

    fmt_trs_meter #(.LEN_W(LEN_W)) u_trs (
        .clk      (clk),
        .rst      (rst),
        .vid_word (vid_word),
        .eav_stb  (eav_stb),
        .evt      (evt),
        .line_len (line_len)
    );

    fmt_frame_meter #(.LEN_W(LEN_W), .LINE_W(LINE_W)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .line_len    (line_len),
        .meas_vld    (meas_vld),
        .meas_len    (meas_len),
        .meas_lines  (meas_lines),
        .meas_active (meas_active),
        .meas_il     (meas_il),
        .meas_bad    (meas_bad)
    );

    fmt_classify #(
        .LEN_W      (LEN_W),
        .LINE_W     (LINE_W),
        .LEN_SHIFT  (LEN_SHIFT),
        .LINE_SHIFT (LINE_SHIFT)
    ) u_cls (
        .meas_len    (meas_len),
        .meas_lines  (meas_lines),
        .meas_active (meas_active),
        .meas_il     (meas_il),
        .meas_bad    (meas_bad),
        .cand        (cand)
    );

    fmt_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .meas_vld (meas_vld),
        .cand     (cand),
        .code_q   (code_q),
        .valid_q  (valid_q)
    );

    assign fmt_code  = code_q;
    assign fmt_valid = valid_q;
    assign is_hd     = code_q[4];
    assign is_pal    = code_q[3];

endmodule

// File: rtl/fmt_raster_detect_chk.sv
`timescale 1ns/1ps
module fmt_raster_detect_chk
    import fmt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [9:0] vid_word,
    input logic       eav_stb,
    input logic [4:0] fmt_code,
    input logic       fmt_valid,
    input logic       is_hd,
    input logic       is_pal,
    input logic       meas_vld
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (fmt_code == 5'd0 && !fmt_valid));

    p_change_at_frame_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(meas_vld) && !$past(rst)) |-> ($stable(fmt_code) && $stable(fmt_valid)));

    p_legal_code_r4: assert property (@(posedge clk) disable iff (rst)
        fmt_valid |-> fmt_code_legal(fmt_code));

    p_rise_after_meas_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(fmt_valid) |-> $past(meas_vld));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !fmt_valid |-> (fmt_code == 5'd0 && !is_hd && !is_pal));

    p_bad_word_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (eav_stb && !fmt_xyz_ok(vid_word)) |=> !meas_vld);

endmodule

bind fmt_raster_detect fmt_raster_detect_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .vid_word  (vid_word),
    .eav_stb   (eav_stb),
    .fmt_code  (fmt_code),
    .fmt_valid (fmt_valid),
    .is_hd     (is_hd),
    .is_pal    (is_pal),
    .meas_vld  (meas_vld)
);

// File: tb/sim_fmt_raster_detect.sv
`timescale 1ns/1ps
module sim_fmt_raster_detect;

    localparam int SH = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] vid_word;
    logic       eav_stb;
    logic [4:0] fmt_code;
    logic       fmt_valid;
    logic       is_hd;
    logic       is_pal;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    int       nom_len   [14];
    int       nom_lines [14];
    int       nom_act   [14];
    int       nom_il    [14];
    bit [4:0] nom_code  [14];

    always #2.5 clk = ~clk;

    fmt_raster_detect #(
        .LEN_W(12), .LINE_W(11), .LEN_SHIFT(SH), .LINE_SHIFT(SH)
    ) u0 (
        .clk(clk), .rst(rst), .vid_word(vid_word), .eav_stb(eav_stb),
        .fmt_code(fmt_code), .fmt_valid(fmt_valid), .is_hd(is_hd), .is_pal(is_pal)
    );

    function automatic logic [9:0] xyz(logic f, logic v);
        return {1'b1, f, v, 1'b1, ~v, ~f, f ^ v, ~(f ^ v), 2'b00};
    endfunction

    task automatic chk(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic check_out(string tag, bit [4:0] ec, bit ev);
        bit [4:0] c;
        c = ev ? ec : 5'd0;
        chk({tag, " code"},      int'(fmt_code),  int'(c));
        chk({tag, " valid"},     int'(fmt_valid), int'(ev));
        chk({tag, " R10 hd"},    int'(is_hd),     int'(c[4]));
        chk({tag, " R10 pal"},   int'(is_pal),    int'(c[3]));
    endtask

    task automatic drive(logic [9:0] w, logic s);
        @(negedge clk);
        vid_word = w;
        eav_stb  = s;
    endtask

    // One frame of scaled raster; checks the previous frame's result early in line 0
    task automatic send_frame(int len, int lines, int act, int il, bit do_chk,
                              bit [4:0] ec, bit ev, string tag, int jit_line, int bad_line);
        int n1, a1, n2, a2;
        n1 = (il != 0) ? lines / 2 : lines;
        a1 = (il != 0) ? act / 2 : act;
        n2 = lines - n1;
        a2 = act - a1;
        for (int k = 0; k < lines; k++) begin
            logic f, v;
            int   ll;
            if (k < n1) begin
                f = 1'b0;
                v = (k < n1 - a1);
            end else begin
                f = 1'b1;
                v = ((k - n1) < n2 - a2);
            end
            ll = (k == jit_line) ? len + 1 : len;
            for (int w = 0; w < ll; w++) begin
                if (w == 0)
                    drive(xyz(f, v), 1'b1);
                else if (k == bad_line && w == 10)
                    drive(xyz(1'b0, 1'b1) ^ 10'h004, 1'b1);
                else
                    drive(10'h040 + 10'(w), 1'b0);
                if (do_chk && k == 0 && w == 4) check_out(tag, ec, ev);
            end
        end
    endtask

    task automatic fmt_frame(int i, bit do_chk, bit [4:0] ec, bit ev, string tag);
        send_frame(nom_len[i] >> SH, nom_lines[i] >> SH, nom_act[i] >> SH, nom_il[i],
                   do_chk, ec, ev, tag, -1, -1);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        bit [4:0] prev;
        string    rq;
        nom_len   = '{3432, 2288, 1716, 3456, 2304, 1728, 2200, 2200, 2200, 2640, 2640, 2376, 2750, 1650};
        nom_lines = '{525, 525, 525, 625, 625, 625, 1125, 1125, 1125, 1125, 1125, 1250, 1125, 750};
        nom_act   = '{448, 448, 448, 544, 544, 544, 1035, 1080, 1080, 1080, 1080, 1080, 1080, 720};
        nom_il    = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 0, 1, 0, 0};
        nom_code  = '{5'b00001, 5'b00010, 5'b00011, 5'b01001, 5'b01010, 5'b01011,
                      5'b10001, 5'b10010, 5'b10011, 5'b11001, 5'b11010,
                      5'b11100, 5'b11101, 5'b10100};

        rst      = 1'b1;
        vid_word = 10'h000;
        eav_stb  = 1'b0;
        repeat (4) @(negedge clk);
        check_out("R1 in reset", 5'd0, 1'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_out("R1 after reset", 5'd0, 1'b0);

        // Sweep every raster: three frames each
        prev = 5'd0;
        for (int i = 0; i < 14; i++) begin
            rq = (i < 6) ? "R4" : (i < 9) ? "R5" : "R6";
            fmt_frame(i, i > 0, prev, 1'b1, "R7 hold previous lock");
            fmt_frame(i, 1'b1, 5'd0, 1'b0, "R7 R8 one frame after change");
            fmt_frame(i, 1'b1, nom_code[i], 1'b1, {rq, " R2 R3 locked code"});
            prev = nom_code[i];
        end

        // Unknown line length
        send_frame(60, 35, 33, 0, 1'b1, prev, 1'b1, "R7 hold before unknown", -1, -1);
        send_frame(60, 35, 33, 0, 1'b1, 5'd0, 1'b0, "R8 unknown length", -1, -1);
        send_frame(60, 35, 33, 0, 1'b1, 5'd0, 1'b0, "R8 unknown length stays", -1, -1);

        // 2376 over 1250 progressive matches nothing
        send_frame(2376 >> SH, 1250 >> SH, 1080 >> SH, 0, 1'b1, 5'd0, 1'b0, "R8 after unknown", -1, -1);
        send_frame(2376 >> SH, 1250 >> SH, 1080 >> SH, 0, 1'b0, 5'd0, 1'b0, "", -1, -1);
        send_frame(2376 >> SH, 1250 >> SH, 1080 >> SH, 0, 1'b1, 5'd0, 1'b0, "R6 wrong scan 2376", -1, -1);

        // 2750 over 1125 interlaced matches nothing
        send_frame(2750 >> SH, 1125 >> SH, 1080 >> SH, 1, 1'b0, 5'd0, 1'b0, "", -1, -1);
        send_frame(2750 >> SH, 1125 >> SH, 1080 >> SH, 1, 1'b0, 5'd0, 1'b0, "", -1, -1);
        send_frame(2750 >> SH, 1125 >> SH, 1080 >> SH, 1, 1'b1, 5'd0, 1'b0, "R6 wrong scan 2750", -1, -1);

        // 2200 interlaced with an active count of neither 1035 nor 1080
        send_frame(2200 >> SH, 1125 >> SH, 30, 1, 1'b0, 5'd0, 1'b0, "", -1, -1);
        send_frame(2200 >> SH, 1125 >> SH, 30, 1, 1'b0, 5'd0, 1'b0, "", -1, -1);
        send_frame(2200 >> SH, 1125 >> SH, 30, 1, 1'b1, 5'd0, 1'b0, "R5 active mismatch", -1, -1);

        // Relock 2200 progressive, then one frame with an uneven line
        fmt_frame(8, 1'b0, 5'd0, 1'b0, "");
        fmt_frame(8, 1'b0, 5'd0, 1'b0, "");
        fmt_frame(8, 1'b1, 5'b10011, 1'b1, "R5 relock");
        send_frame(2200 >> SH, 1125 >> SH, 1080 >> SH, 0, 1'b1, 5'b10011, 1'b1, "R7 hold", 5, -1);
        fmt_frame(8, 1'b1, 5'd0, 1'b0, "R8 uneven line length");

        // Malformed timing word inside an active line is ignored
        send_frame(2200 >> SH, 1125 >> SH, 1080 >> SH, 0, 1'b1, 5'd0, 1'b0, "R7 first clean frame", -1, 20);
        fmt_frame(8, 1'b1, 5'b10011, 1'b1, "R9 malformed word ignored");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule